// File: doc/BRIEF.md
# Fine Phase-Step Tracker with Limit Flag

This block keeps the running total of fine phase steps that have been applied to a clock manager. Each step moves the output phase by one 1/256 of the input clock period. A client asks for a step with a one-cycle enable and a direction bit. After a fixed latency the block answers with a one-cycle done pulse. On that same edge it updates a signed step count. Each mode has its own legal range for the count. A request that would leave that range is still acknowledged, but the count stays where it is and a limit flag is raised. The flag stays up for a minimum number of cycles.

The range is chosen by a mode input, which is captured only while reset is held. Centred mode allows -255 to +255. Positive mode allows 0 to +255. Direct mode allows 0 to 1023. The flag may go up and down again during a sweep, so it is not a safe cue for turning the sweep around. For that reason an optional sweep mode picks the step direction itself. It reverses the direction when the tracked count reaches one of two programmable bounds. The flag plays no part in that decision.

Top module: `ps_tracker`

## Requirements
- R1: While `rst` is high the count is 0, `ovf_flag` and `step_done` are 0, and `sweep_dir` is 1. `mode_sel` is captured only while `rst` is high, and later changes to it have no effect.
- R2: With mode 0 (centred) the count stays within -255..+255. A step that would leave this range leaves the count unchanged, still gives a done pulse, and sets `ovf_flag`.
- R3: With mode 1 (positive) the count stays within 0..+255. A step that would leave this range is handled as in R2.
- R4: With mode 2 or 3 (direct) the count stays within 0..1023. A step that would leave this range is handled as in R2.
- R5: A `step_en` that is sampled high while no step is pending is acknowledged by `step_done`. The pulse is high for exactly one cycle and follows the 4th rising edge, counting the edge that sampled the enable. `step_dir`=1 increments and 0 decrements. The count changes on the same edge that raises `step_done`, and at no other time.
- R6: A `step_en` sampled while a step is pending is ignored. An enable that is sampled while `step_done` is high starts a new step.
- R7: After any out-of-range step, `ovf_flag` stays high for at least 40 cycles. Each further out-of-range step restarts that hold.
- R8: `ovf_flag` falls on the first edge at which two conditions both hold: the hold has run out, and the most recent completed step was in range.
- R9: With `sweep_en`=1 the step direction is taken from `sweep_dir` and `step_dir` is ignored. After each completed step, if the count is at or above `sweep_hi`, `sweep_dir` becomes 0. Otherwise, if the count is at or below `sweep_lo`, `sweep_dir` becomes 1.
- R10: `sweep_dir` changes only on the edge of a completed step, and `ovf_flag` never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Range mode: 0 centred, 1 positive, 2/3 direct. Sampled during reset |
| step_en | input | 1 | One-cycle step request |
| step_dir | input | 1 | 1 increment, 0 decrement |
| sweep_en | input | 1 | Use the internal sweep direction instead of step_dir |
| sweep_lo | input | CNT_W | Signed lower sweep bound |
| sweep_hi | input | CNT_W | Signed upper sweep bound |
| step_done | output | 1 | One-cycle step acknowledge |
| phase_count | output | CNT_W | Signed accumulated step count |
| ovf_flag | output | 1 | Range-limit flag with minimum hold |
| sweep_dir | output | 1 | Sweep direction, 1 = up |

## Verification
The properties assume that `mode_sel` holds a valid code whenever `rst` is high. They also assume that `sweep_lo` is at or below `sweep_hi` and that both bounds lie inside the selected range. The stimulus always applies a reset before it changes mode, so the captured mode is well defined. It picks sweep bounds only from inside the legal range, and it sets them before sweep mode is enabled. Enable and direction bits are random, but long runs of one direction are included so that every mode limit is actually reached.

// File: rtl/ps_pkg.sv
package ps_pkg;
    typedef enum logic [1:0] {
        PS_CENTRED  = 2'd0,
        PS_POSITIVE = 2'd1,
        PS_DIRECT   = 2'd2,
        PS_DIRECT_B = 2'd3
    } ps_mode_e;
endpackage

// File: rtl/ps_limits.sv
module ps_limits
    import ps_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int HALF       = 255,
    parameter int DIRECT_MAX = 1023
) (
    input  ps_mode_e                   mode,
    output logic signed [CNT_W-1:0]    lim_lo,
    output logic signed [CNT_W-1:0]    lim_hi
);
    localparam logic signed [CNT_W-1:0] C_LO = CNT_W'(-HALF);
    localparam logic signed [CNT_W-1:0] C_HI = CNT_W'(HALF);
    localparam logic signed [CNT_W-1:0] D_HI = CNT_W'(DIRECT_MAX);
    localparam logic signed [CNT_W-1:0] ZERO = '0;

    always_comb begin
        case (mode)
            PS_CENTRED: begin
                lim_lo = C_LO;
                lim_hi = C_HI;
            end
            PS_POSITIVE: begin
                lim_lo = ZERO;
                lim_hi = C_HI;
            end
            default: begin
                lim_lo = ZERO;
                lim_hi = D_HI;
            end
        endcase
    end
endmodule

// File: rtl/ps_step_timer.sv
module ps_step_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    output logic accept,
    output logic fire,
    output logic busy
);
    localparam int WW = $clog2(LAT + 1);
    localparam logic [WW-1:0] W_LAST = WW'(LAT - 1);
    localparam logic [WW-1:0] W_ONE  = WW'(1);

    typedef struct packed {
        logic          busy;
        logic [WW-1:0] wait_cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = !st_q.busy && step_en;
        fire   = st_q.busy && (st_q.wait_cnt == W_LAST);
        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.wait_cnt = W_ONE;
        end else if (fire) begin
            st_d.busy     = 1'b0;
        end else if (st_q.busy) begin
            st_d.wait_cnt = st_q.wait_cnt + W_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/ps_ovf_hold.sv
module ps_ovf_hold #(
    parameter int HOLD = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic bad,
    output logic ovf
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] H_LOAD = HW'(HOLD - 1);
    localparam logic [HW-1:0] H_ONE  = HW'(1);

    typedef struct packed {
        logic          ovf;
        logic          last_bad;
        logic [HW-1:0] hold;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // decay of the hold window
        if (st_q.hold != '0)       st_d.hold = st_q.hold - H_ONE;
        else if (!st_q.last_bad)   st_d.ovf  = 1'b0;
        // a completed step updates the record of the last outcome
        if (fire) begin
            st_d.last_bad = bad;
            if (bad) begin
                st_d.ovf  = 1'b1;
                st_d.hold = H_LOAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ovf = st_q.ovf;
endmodule

// File: rtl/ps_tracker.sv
module ps_tracker
    import ps_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int HALF       = 255,
    parameter int DIRECT_MAX = 1023,
    parameter int LAT        = 4,
    parameter int HOLD       = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              mode_sel,
    input  logic                    step_en,
    input  logic                    step_dir,
    input  logic                    sweep_en,
    input  logic signed [CNT_W-1:0] sweep_lo,
    input  logic signed [CNT_W-1:0] sweep_hi,
    output logic                    step_done,
    output logic signed [CNT_W-1:0] phase_count,
    output logic                    ovf_flag,
    output logic                    sweep_dir
);
    localparam int XW = CNT_W + 1;
    localparam logic signed [XW-1:0] X_ONE = XW'(1);

    typedef struct packed {
        ps_mode_e                mode;
        logic signed [CNT_W-1:0] count;
        logic                    dir;
        logic                    sdir;
        logic                    done;
    } trk_t;

    trk_t st_d, st_q;

    logic                    accept, fire, busy, bad;
    logic signed [CNT_W-1:0] lim_lo, lim_hi;
    logic signed [XW-1:0]    cnt_x, nxt_x, lo_x, hi_x;
    logic [1:0]              mode_r;

    ps_limits #(.CNT_W(CNT_W), .HALF(HALF), .DIRECT_MAX(DIRECT_MAX)) u_limits (
        .mode   (st_q.mode),
        .lim_lo (lim_lo),
        .lim_hi (lim_hi)
    );

    ps_step_timer #(.LAT(LAT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .accept  (accept),
        .fire    (fire),
        .busy    (busy)
    );

    ps_ovf_hold #(.HOLD(HOLD)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .bad  (bad),
        .ovf  (ovf_flag)
    );

    always_comb begin
        cnt_x = {st_q.count[CNT_W-1], st_q.count};
        lo_x  = {lim_lo[CNT_W-1], lim_lo};
        hi_x  = {lim_hi[CNT_W-1], lim_hi};
        nxt_x = st_q.dir ? (cnt_x + X_ONE) : (cnt_x - X_ONE);
        bad   = (nxt_x < lo_x) || (nxt_x > hi_x);

        st_d      = st_q;
        st_d.done = fire;
        if (accept) begin
            st_d.dir = sweep_en ? st_q.sdir : step_dir;
        end
        if (fire) begin
            if (!bad) st_d.count = nxt_x[CNT_W-1:0];
            if (st_d.count >= sweep_hi)      st_d.sdir = 1'b0;
            else if (st_d.count <= sweep_lo) st_d.sdir = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= ps_mode_e'(mode_sel);
            st_q.count <= '0;
            st_q.dir   <= 1'b1;
            st_q.sdir  <= 1'b1;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_r      = st_q.mode;
    assign step_done   = st_q.done;
    assign phase_count = st_q.count;
    assign sweep_dir   = st_q.sdir;
endmodule

// File: rtl/ps_tracker_chk.sv
module ps_tracker_chk #(
    parameter int CNT_W      = 11,
    parameter int HALF       = 255,
    parameter int DIRECT_MAX = 1023,
    parameter int HOLD       = 40
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    step_done,
    input logic signed [CNT_W-1:0] phase_count,
    input logic                    ovf_flag,
    input logic                    sweep_dir,
    input logic [1:0]              mode_q,
    input logic                    busy
);
    int lo_c, hi_c, cnt_i;
    logic [15:0] hi_run;

    always_comb begin
        cnt_i = int'(phase_count);
        if (mode_q == 2'd0)      begin lo_c = -HALF; hi_c = HALF; end
        else if (mode_q == 2'd1) begin lo_c = 0;     hi_c = HALF; end
        else                     begin lo_c = 0;     hi_c = DIRECT_MAX; end
    end

    always_ff @(posedge clk) begin
        if (rst)                            hi_run <= '0;
        else if (ovf_flag && hi_run != '1)  hi_run <= hi_run + 16'd1;
        else if (!ovf_flag)                 hi_run <= '0;
    end

    // R2, R3 and R4: the count never leaves the range of the captured mode
    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_i >= lo_c) && (cnt_i <= hi_c));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done);

    assert_count_only_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        !step_done |-> $stable(phase_count));

    assert_done_after_pending_R6: assert property (@(posedge clk) disable iff (rst)
        step_done |-> $past(busy));

    assert_flag_rises_with_done_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> step_done);

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && hi_run != '0) |-> (32'(hi_run) >= HOLD));

    assert_sweep_dir_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        !step_done |-> $stable(sweep_dir));
endmodule

bind ps_tracker ps_tracker_chk #(
    .CNT_W(CNT_W), .HALF(HALF), .DIRECT_MAX(DIRECT_MAX), .HOLD(HOLD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .step_done   (step_done),
    .phase_count (phase_count),
    .ovf_flag    (ovf_flag),
    .sweep_dir   (sweep_dir),
    .mode_q      (mode_r),
    .busy        (busy)
);

// File: tb/test_ps_tracker.sv
`timescale 1ns/1ps
module test_ps_tracker;
    localparam int CNT_W = 11;
    localparam int LAT   = 4;
    localparam int HOLD  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic step_en = 1'b0, step_dir = 1'b0, sweep_en = 1'b0;
    logic signed [CNT_W-1:0] sweep_lo = '0, sweep_hi = 11'sd128;
    logic step_done, ovf_flag, sweep_dir;
    logic signed [CNT_W-1:0] phase_count;

    int checks = 0, errors = 0, cycles = 0;
    bit chk_on = 0;

    always #2 clk = ~clk;

    ps_tracker #(.CNT_W(CNT_W), .LAT(LAT), .HOLD(HOLD)) i_ps_tracker (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .step_en(step_en),
        .step_dir(step_dir), .sweep_en(sweep_en), .sweep_lo(sweep_lo),
        .sweep_hi(sweep_hi), .step_done(step_done), .phase_count(phase_count),
        .ovf_flag(ovf_flag), .sweep_dir(sweep_dir)
    );

    // reference model built from the requirements
    int m_cnt, m_hold, m_w, m_mode;
    bit m_ovf, m_bad, m_busy, m_done, m_sdir, m_dir;

    function automatic int lo_of(int md);
        return (md == 0) ? -255 : 0;
    endfunction
    function automatic int hi_of(int md);
        return (md <= 1) ? 255 : 1023;
    endfunction
    function automatic string cnt_req(int md);
        return (md == 0) ? "R2" : (md == 1) ? "R3" : "R4";
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_w = 0; m_mode = int'(mode_sel);
            m_ovf = 0; m_bad = 0; m_busy = 0; m_done = 0; m_sdir = 1; m_dir = 1;
        end else begin
            bit fire;
            int nxt;
            fire = m_busy && (m_w == LAT - 1);
            if (m_hold > 0) m_hold--;
            else if (!m_bad) m_ovf = 0;
            if (fire) begin
                nxt = m_cnt + (m_dir ? 1 : -1);
                if (nxt < lo_of(m_mode) || nxt > hi_of(m_mode)) begin
                    m_ovf = 1; m_hold = HOLD - 1; m_bad = 1;
                end else begin
                    m_cnt = nxt; m_bad = 0;
                end
                if (m_cnt >= int'(sweep_hi))      m_sdir = 0;
                else if (m_cnt <= int'(sweep_lo)) m_sdir = 1;
            end
            if (m_busy) begin
                if (fire) m_busy = 0; else m_w++;
            end else if (step_en) begin
                m_busy = 1; m_w = 1; m_dir = sweep_en ? m_sdir : step_dir;
            end
            m_done = fire;
        end
        chk_on = 1;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) if (chk_on) begin
        check(step_done === m_done, "R5", "step_done", int'(step_done), int'(m_done));
        check(int'(phase_count) == m_cnt, cnt_req(m_mode), "phase_count", int'(phase_count), m_cnt);
        check(ovf_flag === m_ovf, "R7/R8", "ovf_flag", int'(ovf_flag), int'(m_ovf));
        check(sweep_dir === m_sdir, "R9,R10", "sweep_dir", int'(sweep_dir), int'(m_sdir));
    end

    task automatic do_reset(logic [1:0] md);
        @(negedge clk);
        rst = 1; mode_sel = md; step_en = 0; sweep_en = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic burst(int n, bit dir);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_en = 1; step_dir = dir;
        end
        @(negedge clk);
        step_en = 0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic rand_run(int n);
        bit d = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 300 == 0) d = $urandom_range(0, 1);
            step_en  = ($urandom_range(0, 3) != 0);
            step_dir = ($urandom_range(0, 9) < 8) ? d : ~d;
        end
        @(negedge clk);
        step_en = 0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        int c0, mx, hi_cnt;
        void'($urandom(32'h5eed_1234));

        // R1 reset state
        do_reset(2'd0);
        check(phase_count == 0 && !ovf_flag && !step_done && sweep_dir,
              "R1", "reset state", int'(phase_count), 0);

        // R1 mode change after reset has no effect; stays centred
        @(negedge clk); mode_sel = 2'd2;
        burst(270 * LAT, 1'b1);
        check(int'(phase_count) == 255, "R2", "upper centred limit", int'(phase_count), 255);
        check(ovf_flag == 1'b1, "R2", "flag at upper limit", int'(ovf_flag), 1);

        // R8 flag stays while last step was bad, beyond hold
        repeat (HOLD + 5) @(negedge clk);
        check(ovf_flag == 1'b1, "R8", "flag kept after bad step", int'(ovf_flag), 1);
        burst(1, 1'b0);
        @(negedge clk);
        check(ovf_flag == 1'b0, "R8", "flag dropped after good step", int'(ovf_flag), 0);

        burst(520 * LAT, 1'b0);
        check(int'(phase_count) == -255, "R2", "lower centred limit", int'(phase_count), -255);

        // R6 enables while pending are ignored
        burst(1, 1'b1);
        c0 = int'(phase_count);
        @(negedge clk); step_en = 1; step_dir = 1;
        repeat (LAT - 1) @(negedge clk);
        step_en = 0;
        repeat (LAT + 2) @(negedge clk);
        check(int'(phase_count) == c0 + 1, "R6", "one step from held enable", int'(phase_count), c0 + 1);

        // R3 positive mode
        do_reset(2'd1);
        burst(3 * LAT, 1'b0);
        check(int'(phase_count) == 0, "R3", "positive floor", int'(phase_count), 0);
        check(ovf_flag == 1'b1, "R3", "flag at floor", int'(ovf_flag), 1);
        burst(260 * LAT, 1'b1);
        check(int'(phase_count) == 255, "R3", "positive ceiling", int'(phase_count), 255);

        // R4 direct mode
        do_reset(2'd2);
        burst(1030 * LAT, 1'b1);
        check(int'(phase_count) == 1023, "R4", "direct ceiling", int'(phase_count), 1023);
        check(ovf_flag == 1'b1, "R4", "flag at direct ceiling", int'(ovf_flag), 1);

        // R9 sweep in direct mode between 0 and 128
        do_reset(2'd3);
        sweep_lo = 11'sd0; sweep_hi = 11'sd128;
        @(negedge clk); sweep_en = 1;
        mx = 0; hi_cnt = 0;
        for (int i = 0; i < 450 * LAT; i++) begin
            @(negedge clk);
            step_en = 1; step_dir = $urandom_range(0, 1);
            if (int'(phase_count) > mx) mx = int'(phase_count);
            if (ovf_flag) hi_cnt++;
        end
        step_en = 0;
        repeat (LAT + 2) @(negedge clk);
        check(mx == 128, "R9", "sweep peak", mx, 128);
        check(hi_cnt == 0, "R10", "no flag during in-range sweep", hi_cnt, 0);
        sweep_en = 0;

        // random phases in each mode
        for (int k = 0; k < 4; k++) begin
            do_reset(2'(k));
            sweep_lo = 11'(int'($urandom_range(0, 60)));
            sweep_hi = 11'(int'($urandom_range(80, 200)));
            @(negedge clk); sweep_en = (k == 2);
            rand_run(6000);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule